// File: doc/BRIEF.md
# Bidirectional Four-Bit Shift Register

This block is a small register whose contents can be kept, moved one place toward either end, or replaced by a parallel word on every rising clock edge. A two-bit mode input chooses the operation. A synchronous clear input zeroes the contents and takes priority over every mode. Each end has a serial input that feeds the vacated cell during a shift. The end cells are also brought out as serial outputs, so two or more of these registers can be chained into a longer one.

Bit 3 is the leftmost cell and bit 0 is the rightmost cell. A right shift moves data from bit 3 toward bit 0. A left shift moves data from bit 0 toward bit 3. Every cell is a flip-flop fed by a four-way selector. The selector's inputs are ordered so that the mode value is the selector index: the cell's own value, its left neighbour, its right neighbour, then its parallel input bit.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `clr` is 1 at a rising edge, `q` becomes 0000 after that edge, whatever the value of `mode`.
- R2: With `clr` at 0 and `mode` = 2'b00 (hold), `q` keeps its value across the edge, and `par_in` and both serial inputs have no effect.
- R3: With `mode` = 2'b01 (shift right), each bit i below 3 takes the old bit i+1, and bit 3 takes `rsh_in`.
- R4: With `mode` = 2'b10 (shift left), each bit i above 0 takes the old bit i-1, and bit 0 takes `lsh_in`.
- R5: With `mode` = 2'b11 (load), `q` takes `par_in`.
- R6: `msb_out` always equals `q[3]` and `lsb_out` always equals `q[0]`.
- R7: `q` changes only at a rising clock edge. A change on any input between edges leaves `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Synchronous clear, active high, overrides mode |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| rsh_in | input | 1 | Serial bit entering bit 3 on a right shift |
| lsh_in | input | 1 | Serial bit entering bit 0 on a left shift |
| par_in | input | 4 | Parallel load word |
| q | output | 4 | Register contents, bit 3 leftmost |
| msb_out | output | 1 | Leftmost cell, for chaining |
| lsb_out | output | 1 | Rightmost cell, for chaining |

## Verification
The hardest case to reach from the ports is clear winning over an active mode. A design that lets load or a shift beat clear can still look correct when clear is only ever applied with hold selected. The stimulus table therefore asserts clear together with load, with hold, and with both shift directions. It sets up nonzero contents and a nonzero parallel word or serial bit each time, so a wrong priority shows up as a nonzero result. A second case is ruling out updates between edges. The bench changes the mode and the parallel word in the middle of a cycle, samples `q` before the next edge, and then again after it.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int unsigned BSR_WIDTH = 4;

    // Mode value doubles as the cell selector index:
    // own value, left neighbour, right neighbour, parallel bit.
    typedef enum logic [1:0] {
        SM_HOLD  = 2'b00,
        SM_RIGHT = 2'b01,
        SM_LEFT  = 2'b10,
        SM_LOAD  = 2'b11
    } shift_mode_e;

    function automatic shift_mode_e bits_to_mode(input logic [1:0] b);
        return shift_mode_e'(b);
    endfunction

endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
    import bsr_pkg::*;
(
    input  logic [1:0]  mode_bits,
    output shift_mode_e mode_sel
);
    always_comb begin
        mode_sel = bits_to_mode(mode_bits);
    end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  shift_mode_e sel,
    input  logic        from_left,
    input  logic        from_right,
    input  logic        par_bit,
    output logic        bit_q
);
    logic nxt;

    always_comb begin
        unique case (sel)
            SM_HOLD:  nxt = bit_q;
            SM_RIGHT: nxt = from_left;
            SM_LEFT:  nxt = from_right;
            SM_LOAD:  nxt = par_bit;
            default:  nxt = bit_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) bit_q <= 1'b0;
        else     bit_q <= nxt;
    end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import bsr_pkg::*;
#(
    parameter int unsigned WIDTH = BSR_WIDTH
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             rsh_in,
    input  logic             lsh_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             msb_out,
    output logic             lsb_out
);
    localparam int unsigned TOP = WIDTH - 1;

    shift_mode_e mode_sel;

    bsr_mode_decode u_dec (
        .mode_bits (mode),
        .mode_sel  (mode_sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic lft, rgt;
        if (i == TOP) begin : g_left_end
            assign lft = rsh_in;
        end else begin : g_left_mid
            assign lft = q[i+1];
        end
        if (i == 0) begin : g_right_end
            assign rgt = lsh_in;
        end else begin : g_right_mid
            assign rgt = q[i-1];
        end
        bsr_cell u_cell (
            .clk        (clk),
            .clr        (clr),
            .sel        (mode_sel),
            .from_left  (lft),
            .from_right (rgt),
            .par_bit    (par_in[i]),
            .bit_q      (q[i])
        );
    end

    assign msb_out = q[TOP];
    assign lsb_out = q[0];

    // Contents are defined only once a clear has been seen.
    logic armed;
    always_ff @(posedge clk) begin
        if (clr) armed <= 1'b1;
    end

    assert_clear_zero_R1: assert property (@(posedge clk)
        clr |=> (q == '0));

    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (clr || !armed)
        (mode == 2'b00) |=> $stable(q));

    assert_shift_right_R3: assert property (@(posedge clk) disable iff (clr || !armed)
        (mode == 2'b01) |=> (q == {$past(rsh_in), $past(q[TOP:1])}));

    assert_shift_left_R4: assert property (@(posedge clk) disable iff (clr || !armed)
        (mode == 2'b10) |=> (q == {$past(q[TOP-1:0]), $past(lsh_in)}));

    assert_load_word_R5: assert property (@(posedge clk) disable iff (clr || !armed)
        (mode == 2'b11) |=> (q == $past(par_in)));
endmodule

// File: tb/tb_bidir_shift_reg.sv
module tb_bidir_shift_reg;
    logic       clk = 1'b0;
    logic       clr;
    logic [1:0] mode;
    logic       rsh_in, lsh_in;
    logic [3:0] par_in;
    logic [3:0] q;
    logic       msb_out, lsb_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    bidir_shift_reg dut (
        .clk(clk), .clr(clr), .mode(mode), .rsh_in(rsh_in), .lsh_in(lsh_in),
        .par_in(par_in), .q(q), .msb_out(msb_out), .lsb_out(lsb_out)
    );

    // {clr, mode[1:0], rsh_in, lsh_in, par_in[3:0], expected q[3:0]}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 2'b11, 1'b0, 1'b0, 4'b1011, 4'b1011}, // R5 load
        {1'b0, 2'b00, 1'b1, 1'b1, 4'b0100, 4'b1011}, // R2 hold
        {1'b0, 2'b01, 1'b0, 1'b1, 4'b0000, 4'b0101}, // R3 right, 0 in
        {1'b0, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b1010}, // R3 right, 1 in
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b0101}, // R4 left, 1 in
        {1'b0, 2'b10, 1'b1, 1'b0, 4'b0000, 4'b1010}, // R4 left, 0 in
        {1'b1, 2'b11, 1'b0, 1'b0, 4'b1111, 4'b0000}, // R1 clear beats load
        {1'b0, 2'b11, 1'b0, 1'b0, 4'b0110, 4'b0110}, // R5 load
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b1101}, // R4 left
        {1'b0, 2'b01, 1'b0, 1'b0, 4'b0000, 4'b0110}, // R3 right
        {1'b1, 2'b00, 1'b1, 1'b1, 4'b1111, 4'b0000}, // R1 clear with hold
        {1'b0, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b1000}, // R3 fill from left end
        {1'b0, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b1100}, // R3
        {1'b0, 2'b00, 1'b0, 1'b0, 4'b1111, 4'b1100}, // R2 par ignored
        {1'b1, 2'b01, 1'b1, 1'b1, 4'b0000, 4'b0000}, // R1 clear beats right
        {1'b0, 2'b11, 1'b0, 1'b0, 4'b1001, 4'b1001}, // R5
        {1'b1, 2'b10, 1'b1, 1'b1, 4'b0000, 4'b0000}, // R1 clear beats left
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b0001}  // R4 fill from right end
    };

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_ends(input logic [3:0] exp);
        check4("R6 msb_out", {3'b0, msb_out}, {3'b0, exp[3]});
        check4("R6 lsb_out", {3'b0, lsb_out}, {3'b0, exp[0]});
    endtask

    initial begin : watchdog
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clr = 1'b1; mode = 2'b11; rsh_in = 1'b1; lsh_in = 1'b1; par_in = 4'b1111;
        @(negedge clk);
        @(negedge clk);
        check4("R1 reset state", q, 4'b0000);
        check_ends(4'b0000);

        for (int k = 0; k < NV; k++) begin
            {clr, mode, rsh_in, lsh_in, par_in} = VEC[k][12:4];
            @(negedge clk);
            check4($sformatf("vector %0d (R1-R5 set)", k), q, VEC[k][3:0]);
            check_ends(VEC[k][3:0]);
        end

        // R7: inputs change mid-cycle, q holds until the edge
        clr = 1'b0; mode = 2'b00; par_in = 4'b0000;
        @(negedge clk);
        check4("R7 before change", q, 4'b0001);
        @(posedge clk);
        #2;
        mode = 2'b11; par_in = 4'b1110;
        #1;
        check4("R7 mid-cycle", q, 4'b0001);
        @(negedge clk);
        check4("R7 before edge", q, 4'b0001);
        @(posedge clk);
        #1;
        check4("R7 after edge load", q, 4'b1110);
        check_ends(4'b1110);

        // R2: serial inputs toggled during hold leave contents alone
        @(negedge clk);
        mode = 2'b00; rsh_in = 1'b0; lsh_in = 1'b1; par_in = 4'b0001;
        @(negedge clk);
        rsh_in = 1'b1; lsh_in = 1'b0;
        @(negedge clk);
        check4("R2 hold with serial toggles", q, 4'b1110);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule